// File: doc/BRIEF.md
# Transmit Request Arbiter

This block sits beside a set of outgoing message buffers and decides which of them goes onto the bus next. Software raises a request for a buffer with a one-cycle pulse on that buffer's lane. Raising the request only marks the buffer as ready. Nothing is sent until the bus reports an idle point. At that point the arbiter picks the pending buffer with the strongest priority and issues a one-cycle start pulse together with the buffer index.

Only one message is in flight at a time. The index stays frozen until the bit-level transmitter returns exactly one outcome: success, error or lost arbitration. Success retires the request and raises that buffer's completion flag. Error and lost arbitration leave the request in place and record the cause in a flag of its own. A failed buffer competes again at the next idle point, with no help from software.

A buffer's contents may be rewritten only while its request is clear, and the block reports this per buffer. An interrupt line combines the enabled completion flags with a shared error flag.

Top module: `txarb_top`

## Requirements
- R1: After a synchronous reset, all requests, per-buffer flags, `err_int`, `busy`, `tx_start`, `sel_idx` and `irq` are zero.
- R2: A `req_set` pulse sets the request of a buffer whose request is clear. On a buffer whose request is already set, the pulse has no effect on any state. `wr_allow` is the inverse of `req_o`.
- R3: An accepted request set clears that buffer's `err_flag` and `larb_flag`.
- R4: A start needs three conditions in one cycle: nothing is in flight, `bus_idle` is high and at least one request is set. When they hold, `tx_start` is high for exactly one cycle, in the following cycle, and `busy` rises with it.
- R5: The start selects the pending buffer with the largest priority. Buffer i's priority is the unsigned 2-bit field `prio[2i+1:2i]`. On a tie, the higher buffer index wins.
- R6: While `busy` is high, `sel_idx` holds and no new start occurs. Outcome strobes arriving while `busy` is low have no effect.
- R7: A `tx_done` while busy has these effects one cycle later: the selected request is clear, its `done_flag` is set and `busy` is low.
- R8: A `tx_err` while busy has these effects one cycle later: the request stays set, the buffer's `err_flag` and the shared `err_int` are set and `busy` is low.
- R9: A `tx_larb` while busy has these effects one cycle later: the request stays set, the buffer's `larb_flag` is set and `busy` is low.
- R10: When strobes arrive together, `tx_done` wins over `tx_err`, and `tx_err` wins over `tx_larb`. Only the winning outcome takes effect.
- R11: `irq` is high one cycle after any `done_flag` whose `int_en` bit is set is high, or after `err_int` is high.
- R12: `done_clr` clears the completion flags and `err_int_clr` clears `err_int`. When a set and a clear of the same flag arrive in the same cycle, the set wins.
- R13: A buffer that failed is selected again at the next idle point without any new request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NBUF | Per-buffer request set pulse |
| prio | input | NBUF*PW | Packed per-buffer priority fields |
| int_en | input | NBUF | Per-buffer completion interrupt enable |
| done_clr | input | NBUF | Per-buffer completion flag clear |
| err_int_clr | input | 1 | Clear for the shared error flag |
| bus_idle | input | 1 | Bus available indication |
| tx_done | input | 1 | Transmitter success strobe |
| tx_err | input | 1 | Transmitter error strobe |
| tx_larb | input | 1 | Transmitter lost-arbitration strobe |
| busy | output | 1 | A message is in flight |
| tx_start | output | 1 | One-cycle start pulse |
| sel_idx | output | IDXW | Index of the buffer in flight |
| req_o | output | NBUF | Pending requests |
| wr_allow | output | NBUF | Buffer may be rewritten |
| done_flag | output | NBUF | Per-buffer completion flags |
| err_flag | output | NBUF | Per-buffer error flags |
| larb_flag | output | NBUF | Per-buffer lost-arbitration flags |
| err_int | output | 1 | Shared error flag |
| irq | output | 1 | Registered interrupt line |

## Verification
Two events can collide in one cycle: a completion strobe for the buffer in flight and a request pulse from software. The bench provokes this by pulsing `tx_done`, `tx_err` and `tx_larb` together with `req_set` for a different, idle buffer. One cycle later it checks that the retired buffer's request is clear, that the new buffer's request is set and that neither losing outcome left a trace. The bench also lands a clear and a set of the same completion flag in one cycle and expects the flag to remain set.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  typedef enum logic [1:0] {OC_NONE, OC_OK, OC_ERR, OC_LARB} txarb_oc_e;

  // Outcome of the message in flight; success outranks error, error outranks lost arbitration.
  function automatic txarb_oc_e txarb_decode(logic active, logic ok, logic err, logic larb);
    if (!active)   return OC_NONE;
    else if (ok)   return OC_OK;
    else if (err)  return OC_ERR;
    else if (larb) return OC_LARB;
    else           return OC_NONE;
  endfunction
endpackage

// File: rtl/txarb_pick.sv
module txarb_pick #(
  parameter int NBUF = 4,
  parameter int PW   = 2,
  parameter int IDXW = 2
) (
  input  logic [NBUF-1:0]    req,
  input  logic [NBUF*PW-1:0] prio,
  output logic               any,
  output logic [IDXW-1:0]    win
);
  logic [PW-1:0] best;

  // Ascending scan with >= so an equal priority at a higher index takes over.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (req[i] && (!any || prio[i*PW +: PW] >= best)) begin
        any  = 1'b1;
        win  = IDXW'(i);
        best = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/txarb_slot.sv
module txarb_slot
  import txarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_req,
  input  logic      hit,
  input  txarb_oc_e oc,
  input  logic      clr_done,
  output logic      req_q,
  output logic      done_q,
  output logic      err_q,
  output logic      larb_q
);
  logic accept;
  assign accept = set_req && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      larb_q <= 1'b0;
    end else begin
      if (hit && oc == OC_OK) req_q <= 1'b0;
      else if (accept)        req_q <= 1'b1;

      if (hit && oc == OC_OK) done_q <= 1'b1;
      else if (clr_done)      done_q <= 1'b0;

      if (hit && oc == OC_ERR) err_q <= 1'b1;
      else if (accept)         err_q <= 1'b0;

      if (hit && oc == OC_LARB) larb_q <= 1'b1;
      else if (accept)          larb_q <= 1'b0;
    end
  end
endmodule

// File: rtl/txarb_top.sv
module txarb_top
  import txarb_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int PW   = 2,
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NBUF-1:0]    req_set,
  input  logic [NBUF*PW-1:0] prio,
  input  logic [NBUF-1:0]    int_en,
  input  logic [NBUF-1:0]    done_clr,
  input  logic               err_int_clr,
  input  logic               bus_idle,
  input  logic               tx_done,
  input  logic               tx_err,
  input  logic               tx_larb,
  output logic               busy,
  output logic               tx_start,
  output logic [IDXW-1:0]    sel_idx,
  output logic [NBUF-1:0]    req_o,
  output logic [NBUF-1:0]    wr_allow,
  output logic [NBUF-1:0]    done_flag,
  output logic [NBUF-1:0]    err_flag,
  output logic [NBUF-1:0]    larb_flag,
  output logic               err_int,
  output logic               irq
);
  txarb_oc_e       oc;
  logic            any_pend;
  logic [IDXW-1:0] win_idx;

  assign oc       = txarb_decode(busy, tx_done, tx_err, tx_larb);
  assign wr_allow = ~req_o;

  txarb_pick #(.NBUF(NBUF), .PW(PW), .IDXW(IDXW)) u_pick (
    .req  (req_o),
    .prio (prio),
    .any  (any_pend),
    .win  (win_idx)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    txarb_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .set_req  (req_set[g]),
      .hit      (busy && sel_idx == IDXW'(g)),
      .oc       (oc),
      .clr_done (done_clr[g]),
      .req_q    (req_o[g]),
      .done_q   (done_flag[g]),
      .err_q    (err_flag[g]),
      .larb_q   (larb_flag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tx_start <= 1'b0;
      sel_idx  <= '0;
      err_int  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      if (busy) begin
        if (oc != OC_NONE) busy <= 1'b0;
      end else if (bus_idle && any_pend) begin
        busy     <= 1'b1;
        tx_start <= 1'b1;
        sel_idx  <= win_idx;
      end

      if (oc == OC_ERR)     err_int <= 1'b1;
      else if (err_int_clr) err_int <= 1'b0;

      irq <= (|(done_flag & int_en)) | err_int;
    end
  end
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk #(
  parameter int NBUF = 4,
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NBUF-1:0] req_set,
  input logic            tx_done,
  input logic            tx_err,
  input logic            tx_larb,
  input logic            busy,
  input logic            tx_start,
  input logic [IDXW-1:0] sel_idx,
  input logic [NBUF-1:0] req_o,
  input logic [NBUF-1:0] done_flag,
  input logic [NBUF-1:0] err_flag,
  input logic [NBUF-1:0] larb_flag,
  input logic            err_int
);
  // R2
  req_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_o & ~$past(req_o) & ~$past(req_set)) == '0));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (busy && req_o[sel_idx]));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_done && !tx_err && !tx_larb) |=> ($stable(sel_idx) && busy && !tx_start));

  // R7
  done_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_done) |=> (!req_o[$past(sel_idx)] && done_flag[$past(sel_idx)] && !busy));

  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_done && tx_err) |=> (req_o[$past(sel_idx)] && err_flag[$past(sel_idx)] && err_int));

  // R9
  larb_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_done && !tx_err && tx_larb) |=> (req_o[$past(sel_idx)] && larb_flag[$past(sel_idx)]));
endmodule

bind txarb_top txarb_chk #(.NBUF(NBUF), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_set   (req_set),
  .tx_done   (tx_done),
  .tx_err    (tx_err),
  .tx_larb   (tx_larb),
  .busy      (busy),
  .tx_start  (tx_start),
  .sel_idx   (sel_idx),
  .req_o     (req_o),
  .done_flag (done_flag),
  .err_flag  (err_flag),
  .larb_flag (larb_flag),
  .err_int   (err_int)
);

// File: tb/tb_txarb_top.sv
module tb_txarb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req_set = '0, int_en = '0, done_clr = '0;
  logic [7:0] prio = 8'b11_11_00_01; // b3=3 b2=3 b1=0 b0=1
  logic       err_int_clr = 1'b0, bus_idle = 1'b0;
  logic       tx_done = 1'b0, tx_err = 1'b0, tx_larb = 1'b0;
  logic       busy, tx_start, err_int, irq;
  logic [1:0] sel_idx;
  logic [3:0] req_o, wr_allow, done_flag, err_flag, larb_flag;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  txarb_top dut (
    .clk(clk), .rst(rst), .req_set(req_set), .prio(prio), .int_en(int_en),
    .done_clr(done_clr), .err_int_clr(err_int_clr), .bus_idle(bus_idle),
    .tx_done(tx_done), .tx_err(tx_err), .tx_larb(tx_larb), .busy(busy),
    .tx_start(tx_start), .sel_idx(sel_idx), .req_o(req_o), .wr_allow(wr_allow),
    .done_flag(done_flag), .err_flag(err_flag), .larb_flag(larb_flag),
    .err_int(err_int), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic kick();
    bus_idle = 1'b1;
    @(negedge clk);
    bus_idle = 1'b0;
  endtask

  task automatic t_reset();
    eq("R1 req", req_o, 0);
    eq("R1 flags", {done_flag, err_flag, larb_flag}, 0);
    eq("R1 ctl", {busy, tx_start, err_int, irq, sel_idx}, 0);
  endtask

  task automatic t_noidle();
    req_set = 4'b0010; @(negedge clk); req_set = '0;
    eq("R2 req set", req_o, 4'b0010);
    eq("R2 wr_allow", wr_allow, 4'b1101);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      eq("R4 no start without idle", {busy, tx_start}, 0);
    end
  endtask

  task automatic t_prio();
    req_set = 4'b1101; @(negedge clk); req_set = '0;
    eq("R2 req all", req_o, 4'b1111);
    kick();
    eq("R4 start pulse", {tx_start, busy}, 2'b11);
    eq("R5 tie to higher index", sel_idx, 3);
    @(negedge clk);
    eq("R4 start one cycle", tx_start, 0);
  endtask

  task automatic t_hold();
    req_set = 4'b0010; bus_idle = 1'b1;
    @(negedge clk); req_set = '0;
    @(negedge clk); bus_idle = 1'b0;
    eq("R6 sel held", sel_idx, 3);
    eq("R6 no restart", {busy, tx_start}, 2'b10);
    eq("R2 set on pending ignored", req_o, 4'b1111);
  endtask

  task automatic t_ok();
    int_en = 4'b1000;
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    eq("R7 req cleared", req_o, 4'b0111);
    eq("R7 done flag", done_flag, 4'b1000);
    eq("R7 idle", busy, 0);
    eq("R11 irq not yet", irq, 0);
    @(negedge clk);
    eq("R11 irq", irq, 1);
    done_clr = 4'b1000; @(negedge clk); done_clr = '0;
    eq("R12 done clr", done_flag, 0);
    @(negedge clk);
    eq("R11 irq drops", irq, 0);
  endtask

  task automatic t_err();
    kick();
    eq("R5 sel b2", sel_idx, 2);
    tx_err = 1'b1; @(negedge clk); tx_err = 1'b0;
    eq("R8 req kept", req_o, 4'b0111);
    eq("R8 err flags", {err_flag, err_int}, 5'b0100_1);
    @(negedge clk);
    eq("R11 irq on err", irq, 1);
    kick();
    eq("R13 retry start", {tx_start, sel_idx}, 3'b1_10);
    err_int_clr = 1'b1; @(negedge clk); err_int_clr = 1'b0;
    eq("R12 err_int clr", err_int, 0);
  endtask

  task automatic t_larb();
    tx_larb = 1'b1; @(negedge clk); tx_larb = 1'b0;
    eq("R9 req kept", req_o, 4'b0111);
    eq("R9 larb flag", larb_flag, 4'b0100);
    eq("R9 idle", busy, 0);
  endtask

  task automatic t_prec();
    kick();
    eq("R13 again b2", sel_idx, 2);
    tx_done = 1'b1; tx_err = 1'b1; tx_larb = 1'b1; req_set = 4'b1000;
    @(negedge clk);
    tx_done = 1'b0; tx_err = 1'b0; tx_larb = 1'b0; req_set = '0;
    eq("R10 done wins req", req_o, 4'b1011);
    eq("R10 done flag", done_flag, 4'b0100);
    eq("R10 no err outcome", err_int, 0);
    eq("R10 old flags kept", {err_flag, larb_flag}, 8'b0100_0100);
  endtask

  task automatic t_reflag();
    req_set = 4'b0100; @(negedge clk); req_set = '0;
    eq("R3 flags cleared", {err_flag, larb_flag}, 0);
    eq("R3 req set", req_o, 4'b1111);
  endtask

  task automatic t_idle_strobe();
    tx_done = 1'b1; tx_err = 1'b1; @(negedge clk); tx_done = 1'b0; tx_err = 1'b0;
    eq("R6 idle strobe req", req_o, 4'b1111);
    eq("R6 idle strobe flags", {done_flag, err_int}, 5'b0100_0);
  endtask

  task automatic t_setwins();
    kick();
    eq("R5 sel b3", sel_idx, 3);
    tx_done = 1'b1; done_clr = 4'b1000; @(negedge clk); tx_done = 1'b0; done_clr = '0;
    eq("R12 set beats clear", done_flag, 4'b1100);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_noidle();
    t_prio();
    t_hold();
    t_ok();
    t_err();
    t_larb();
    t_prec();
    t_reflag();
    t_idle_strobe();
    t_setwins();
    summary();
  end
endmodule